// File: doc/BRIEF.md
# Rotor strobe timing generator

This block turns a synchronised once-per-revolution shaft tick into the trigger set used to photograph spinning blades. It counts the clock cycles between successive shaft ticks and uses the last count as the length of the coming revolution. From that count it places a revolution marker, a train of n evenly spread marks, one strobe per tracked blade starting at a programmable angular offset, and a 12-bit sawtooth code for a ramp DAC. Because every position is a fraction of the measured period, the triggers stay locked to blade angle while the rotor speeds up or slows down.

All phase positions are produced by fractional-step accumulators instead of dividers. Each accumulator adds a step every clock and subtracts the period when it overflows, so no divide logic is needed. A watchdog on the shaft tick suppresses every derived output when the rotor stops or the sensor fails. After such a stall the block warms up again before it drives any output.

Top module: `rotor_strobe_gen`

## Requirements
- R1: A rising edge of `shaft_tick` sampled at a clock edge makes `rev_mark` high for exactly the next clock cycle, once the block is warmed up. The cycle count between two sampled rising edges becomes the period P used for the revolution that the second edge opens. Call t the number of cycles since the opening edge, so t = 0 in the cycle in which `rev_mark` is high.
- R2: After reset, `rev_mark`, `multi_mark` and `blade_strobe` stay low and `ramp_code` stays 0 until the third rising edge. That edge is the first one that follows two complete measured revolutions.
- R3: `multi_mark` is high at t = 0. It is also high at every t > 0 where floor(t·n/P) differs from floor((t−1)·n/P), with n = `pulses_per_rev`. This gives n marks per revolution of the measured length.
- R4: `ramp_code` equals min(4095, floor(t·4096/P)). It is 0 at t = 0, rises by at most one code per cycle and reaches 4095 in the last cycle of a revolution of the measured length. This holds for P ≥ 4096.
- R5: The first blade strobe starts at t = D, where D = floor(P·A/4096) and A = `offset_angle` is in units of 1/4096 revolution. A is sampled on the opening edge.
- R6: With u = t − D and B = `blade_count`, a further strobe starts at every u > 0 where floor(u·B/P) differs from floor((u−1)·B/P). Such a strobe starts only while fewer than B strobes have started in this revolution. B = 0 gives no strobes.
- R7: `blade_strobe` is high in each cycle that lies within W cycles of the latest strobe start, the start cycle included, with W = `strobe_len` ≥ 1. A new start inside that window restarts the W-cycle window.
- R8: If the cycle count since the last rising edge reaches the parameter TIMEOUT, `stalled` goes high in that cycle. While it is high, all other outputs are low or 0 and the pending strobe window is cancelled.
- R9: A rising edge clears `stalled` in the next cycle and counts as the first edge of a new warm-up, so R2 applies again from that edge.
- R10: When a revolution lasts longer than the measured P, `ramp_code` holds at 4095 until the next edge. The mark and strobe schedules of R3 and R6 keep running with the same P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shaft_tick | input | 1 | Synchronised once-per-revolution pulse |
| pulses_per_rev | input | N_W | Marks per revolution, n |
| blade_count | input | BLADE_W | Number of blades tracked, B |
| offset_angle | input | ANG_W | Offset of the first strobe in 1/4096 revolution |
| strobe_len | input | PW_W | Strobe width in clock cycles, W |
| rev_mark | output | 1 | One-cycle marker at the start of each revolution |
| multi_mark | output | 1 | n-per-revolution mark train |
| blade_strobe | output | 1 | Blade strobe |
| ramp_code | output | RAMP_W | Sawtooth code for the ramp DAC |
| stalled | output | 1 | No shaft tick within TIMEOUT cycles |

## Verification
The assertions take it for granted that `pulses_per_rev` and `blade_count` are below the period and stay still while revolutions are active. They also assume the measured period is at least 4096 cycles, so the ramp never needs more than one code per cycle. The stimulus changes configuration only while the block is stalled, and it uses shaft gaps between 4500 and 6000 cycles. The high phase of each shaft pulse lasts several cycles, so edge detection, rather than pulse level, sets the revolution start.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    // Warm-up progress: edges seen since reset or since a stall.
    typedef enum logic [1:0] {
        WARM_NONE  = 2'd0,
        WARM_ONE   = 2'd1,
        WARM_TWO   = 2'd2,
        WARM_READY = 2'd3
    } warm_e;

endpackage

// File: rtl/rsg_rev_meter.sv
module rsg_rev_meter
    import rsg_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int ANG_W   = 12,
    parameter int TIMEOUT = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shaft_tick,
    input  logic [ANG_W-1:0] offset_angle,
    output logic             edge_o,
    output logic [CNT_W-1:0] t_next_o,
    output logic [CNT_W-1:0] period_next_o,
    output logic [CNT_W-1:0] delay_next_o,
    output logic             valid_next_o,
    output logic             valid_q_o,
    output logic             stall_next_o,
    output logic             stall_q_o
);
    localparam int PROD_W = CNT_W + ANG_W;
    localparam logic [CNT_W:0] TO_V = (CNT_W+1)'(TIMEOUT);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] delay;
        warm_e            warm;
        logic             valid;
        logic             stall;
    } meter_t;

    meter_t q, d;
    logic              edge_now;
    logic [CNT_W:0]    cnt_inc;
    logic [PROD_W-1:0] prod;

    always_comb begin
        d        = q;
        edge_now = shaft_tick & ~q.prev;
        d.prev   = shaft_tick;
        cnt_inc  = {1'b0, q.cnt} + 1'b1;
        prod     = PROD_W'(cnt_inc[CNT_W-1:0]) * PROD_W'(offset_angle);
        if (edge_now) begin
            d.cnt    = '0;
            d.period = cnt_inc[CNT_W-1:0];
            d.delay  = CNT_W'(prod >> ANG_W);
            d.valid  = (q.warm == WARM_TWO || q.warm == WARM_READY) && !q.stall;
            if (q.stall)
                d.warm = WARM_ONE;
            else if (q.warm != WARM_READY)
                d.warm = warm_e'(q.warm + 2'd1);
            d.stall  = 1'b0;
        end else if (!q.stall) begin
            d.cnt = cnt_inc[CNT_W-1:0];
            if (cnt_inc == TO_V) begin
                d.stall = 1'b1;
                d.valid = 1'b0;
                d.warm  = WARM_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{prev: 1'b0, cnt: '0, period: '0, delay: '0,
                   warm: WARM_NONE, valid: 1'b0, stall: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign edge_o        = edge_now;
    assign t_next_o      = d.cnt;
    assign period_next_o = d.period;
    assign delay_next_o  = d.delay;
    assign valid_next_o  = d.valid;
    assign valid_q_o     = q.valid;
    assign stall_next_o  = d.stall;
    assign stall_q_o     = q.stall;

    AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stall && !(shaft_tick && !q.prev)) |=> $stable(q.cnt)); // R8

    AST_EDGE_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (shaft_tick && !q.prev) |=> (!q.stall && q.cnt == '0)); // R9

endmodule

// File: rtl/rsg_frac_tick.sv
module rsg_frac_tick #(
    parameter int ACC_W  = 20,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              restart_tick,
    input  logic              advance,
    input  logic [STEP_W-1:0] step,
    input  logic [ACC_W-1:0]  modulus,
    output logic              tick
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } frac_t;

    frac_t q, d;
    logic [ACC_W:0] sum;

    always_comb begin
        d    = q;
        tick = 1'b0;
        sum  = {1'b0, q.acc} + (ACC_W+1)'(step);
        if (restart) begin
            d.acc = '0;
            tick  = restart_tick;
        end else if (advance) begin
            if (sum >= {1'b0, modulus}) begin
                d.acc = ACC_W'(sum - {1'b0, modulus});
                tick  = 1'b1;
            end else begin
                d.acc = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{acc: '0};
        else        q <= d;
    end

endmodule

// File: rtl/rotor_strobe_gen.sv
module rotor_strobe_gen #(
    parameter int CNT_W   = 20,
    parameter int N_W     = 6,
    parameter int BLADE_W = 4,
    parameter int ANG_W   = 12,
    parameter int RAMP_W  = 12,
    parameter int PW_W    = 10,
    parameter int TIMEOUT = 1000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shaft_tick,
    input  logic [N_W-1:0]     pulses_per_rev,
    input  logic [BLADE_W-1:0] blade_count,
    input  logic [ANG_W-1:0]   offset_angle,
    input  logic [PW_W-1:0]    strobe_len,
    output logic               rev_mark,
    output logic               multi_mark,
    output logic               blade_strobe,
    output logic [RAMP_W-1:0]  ramp_code,
    output logic               stalled
);
    localparam logic [RAMP_W-1:0] RAMP_MAX  = {RAMP_W{1'b1}};
    localparam logic [RAMP_W:0]   RAMP_STEP = (RAMP_W+1)'(1) << RAMP_W;

    typedef struct packed {
        logic [RAMP_W-1:0]  ramp;
        logic [BLADE_W-1:0] bcount;
        logic [PW_W-1:0]    wcnt;
        logic               rev;
        logic               multi;
        logic               strobe;
    } out_t;

    out_t q, d;

    logic             edge_now, valid_n, valid_q, stall_n, stall_q;
    logic [CNT_W-1:0] t_n, p_n, d_n;
    logic             n_tick, r_tick, b_tick;
    logic             b_restart, b_advance, b_start;
    logic [BLADE_W-1:0] bc_base;

    rsg_rev_meter #(.CNT_W(CNT_W), .ANG_W(ANG_W), .TIMEOUT(TIMEOUT)) u_meter (
        .clk(clk), .rst_n(rst_n), .shaft_tick(shaft_tick),
        .offset_angle(offset_angle), .edge_o(edge_now), .t_next_o(t_n),
        .period_next_o(p_n), .delay_next_o(d_n), .valid_next_o(valid_n),
        .valid_q_o(valid_q), .stall_next_o(stall_n), .stall_q_o(stall_q)
    );

    rsg_frac_tick #(.ACC_W(CNT_W), .STEP_W(N_W)) u_multi (
        .clk(clk), .rst_n(rst_n), .restart(edge_now), .restart_tick(1'b1),
        .advance(1'b1), .step(pulses_per_rev), .modulus(p_n), .tick(n_tick)
    );

    rsg_frac_tick #(.ACC_W(CNT_W), .STEP_W(RAMP_W+1)) u_ramp (
        .clk(clk), .rst_n(rst_n), .restart(edge_now), .restart_tick(1'b0),
        .advance(q.ramp != RAMP_MAX), .step(RAMP_STEP), .modulus(p_n),
        .tick(r_tick)
    );

    assign bc_base   = edge_now ? '0 : q.bcount;
    assign b_restart = (t_n == d_n);
    assign b_advance = (t_n > d_n) && (bc_base < blade_count);

    rsg_frac_tick #(.ACC_W(CNT_W), .STEP_W(BLADE_W)) u_blade (
        .clk(clk), .rst_n(rst_n), .restart(b_restart),
        .restart_tick(blade_count != '0), .advance(b_advance),
        .step(blade_count), .modulus(p_n), .tick(b_tick)
    );

    assign b_start = b_tick & valid_n;

    always_comb begin
        d        = q;
        d.rev    = edge_now & valid_n;
        d.multi  = n_tick & valid_n;
        if (!valid_n || edge_now)
            d.ramp = '0;
        else
            d.ramp = q.ramp + RAMP_W'(r_tick);
        d.bcount = (b_restart ? '0 : bc_base) + BLADE_W'(b_tick);
        if (stall_n) begin
            d.wcnt   = '0;
            d.strobe = 1'b0;
        end else begin
            d.strobe = b_start || (q.wcnt != '0);
            if (b_start)
                d.wcnt = (strobe_len == '0) ? '0 : strobe_len - 1'b1;
            else if (q.wcnt != '0)
                d.wcnt = q.wcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ramp: '0, bcount: '0, wcnt: '0,
                           rev: 1'b0, multi: 1'b0, strobe: 1'b0};
        else        q <= d;
    end

    assign rev_mark     = q.rev;
    assign multi_mark   = q.multi;
    assign blade_strobe = q.strobe;
    assign ramp_code    = q.ramp;
    assign stalled      = stall_q;

    AST_REV_RAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rev_mark |-> (ramp_code == '0 && multi_mark)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> (!rev_mark && !multi_mark && ramp_code == '0)); // R2

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && $past(valid_q) && !rev_mark) |->
        (ramp_code == $past(ramp_code) || ramp_code == $past(ramp_code) + 1'b1)); // R4

    AST_BLADE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        q.bcount <= blade_count); // R6

    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!rev_mark && !multi_mark && !blade_strobe && ramp_code == '0)); // R8

endmodule

// File: tb/rotor_strobe_gen_bench.sv
module rotor_strobe_gen_bench;
    localparam int CNT_W   = 16;
    localparam int N_W     = 6;
    localparam int BLADE_W = 4;
    localparam int ANG_W   = 12;
    localparam int RAMP_W  = 12;
    localparam int PW_W    = 10;
    localparam int TO      = 12000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shaft_tick = 1'b0;
    logic [N_W-1:0]     n_cfg = 6'd7;
    logic [BLADE_W-1:0] b_cfg = 4'd3;
    logic [ANG_W-1:0]   a_cfg = 12'd1024;
    logic [PW_W-1:0]    w_cfg = 10'd4;
    logic rev_mark, multi_mark, blade_strobe, stalled;
    logic [RAMP_W-1:0] ramp_code;

    always #5 clk = ~clk;

    rotor_strobe_gen #(.CNT_W(CNT_W), .N_W(N_W), .BLADE_W(BLADE_W),
        .ANG_W(ANG_W), .RAMP_W(RAMP_W), .PW_W(PW_W), .TIMEOUT(TO))
    u_rotor_strobe_gen (
        .clk(clk), .rst_n(rst_n), .shaft_tick(shaft_tick),
        .pulses_per_rev(n_cfg), .blade_count(b_cfg), .offset_angle(a_cfg),
        .strobe_len(w_cfg), .rev_mark(rev_mark), .multi_mark(multi_mark),
        .blade_strobe(blade_strobe), .ramp_code(ramp_code), .stalled(stalled)
    );

    int errors = 0;
    int checks = 0;
    int act_cnt = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    longint m_t, m_p, m_d, m_abs, m_last;
    int     m_edges;
    bit     m_stall, m_valid, m_prev;
    bit     e_rev, e_multi, e_strobe;
    longint e_ramp;

    function automatic bit blade_start(longint t, longint p, longint dd, longint b);
        longint u;
        u = t - dd;
        if (u < 0 || b == 0) return 1'b0;
        if (u == 0) return 1'b1;
        return ((u * b) / p != ((u - 1) * b) / p) && (((u - 1) * b) / p + 1 < b);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_t = 0; m_p = 0; m_d = 0; m_abs = 0; m_last = -1000000000;
            m_edges = 0; m_stall = 0; m_valid = 0; m_prev = 0;
            e_rev = 0; e_multi = 0; e_strobe = 0; e_ramp = 0;
        end else begin
            m_abs++;
            if (shaft_tick && !m_prev) begin
                m_valid = (m_edges >= 2) && !m_stall;
                m_edges = m_stall ? 1 : ((m_edges < 3) ? m_edges + 1 : 3);
                m_stall = 0;
                m_p = m_t + 1;
                m_d = (m_p * longint'(a_cfg)) / 4096;
                m_t = 0;
            end else if (!m_stall) begin
                m_t++;
                if (m_t == TO) begin
                    m_stall = 1; m_valid = 0; m_edges = 0;
                end
            end
            m_prev = shaft_tick;
            if (m_stall) m_last = -1000000000;
            if (m_valid) begin
                e_rev   = (m_t == 0);
                e_multi = (m_t == 0) ||
                          ((m_t * longint'(n_cfg)) / m_p != ((m_t - 1) * longint'(n_cfg)) / m_p);
                e_ramp  = (m_t * 4096) / m_p;
                if (e_ramp > 4095) e_ramp = 4095;
                if (blade_start(m_t, m_p, m_d, longint'(b_cfg))) m_last = m_abs;
            end else begin
                e_rev = 0; e_multi = 0; e_ramp = 0;
            end
            e_strobe = !m_stall && (m_abs - m_last < longint'(w_cfg));
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1", "rev_mark", rev_mark, e_rev);
            chk("R3", "multi_mark", multi_mark, e_multi);
            chk("R4/R10", "ramp_code", ramp_code, e_ramp);
            chk("R5/R6/R7", "blade_strobe", blade_strobe, e_strobe);
            chk("R8", "stalled", stalled, m_stall);
            if (rev_mark || multi_mark || blade_strobe || ramp_code != 0) act_cnt++;
        end
    end

    task automatic revolution(input int gap);
        @(negedge clk) shaft_tick = 1'b1;
        repeat (3) @(negedge clk);
        shaft_tick = 1'b0;
        repeat (gap - 4) @(negedge clk);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        chk("R2", "reset rev_mark", rev_mark, 0);
        chk("R2", "reset ramp_code", ramp_code, 0);
        rst_n = 1'b1;
        repeat (12500) @(negedge clk);
        chk("R8", "stalled after silent start", stalled, 1);

        // Phase 1: steady rotor, then slower rotor
        act_cnt = 0;
        revolution(5000);
        revolution(5000);
        chk("R2", "outputs before two measured revolutions", act_cnt, 0);
        chk("R9", "stall cleared by shaft edge", stalled, 0);
        repeat (4) revolution(5000);
        repeat (3) revolution(6000);
        @(negedge clk) shaft_tick = 1'b1;
        repeat (3) @(negedge clk);
        shaft_tick = 1'b0;
        repeat (12100) @(negedge clk);
        chk("R8", "stalled after rotor stop", stalled, 1);

        // Phase 2: new configuration, overlapping strobe windows
        n_cfg = 6'd5; b_cfg = 4'd5; a_cfg = 12'd3000; w_cfg = 10'd1000;
        act_cnt = 0;
        revolution(4500);
        revolution(4500);
        chk("R9", "warm-up again after stall", act_cnt, 0);
        repeat (4) revolution(4500);
        @(negedge clk) shaft_tick = 1'b1;
        repeat (3) @(negedge clk);
        shaft_tick = 1'b0;
        repeat (200) @(negedge clk);
        chk("R1", "rev_mark low mid-revolution", rev_mark, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule